// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a fully associative cache of address translations. Each slot maps one virtual page to one physical page. A slot also records the address-space identifier that owns it, its page size (4 KB, 2 MB or 1 GB) and an attribute byte that carries the cacheability and permission bits. A lookup presents a virtual address and the identifier of the running address space. One clock later the block answers with hit or miss, the translated physical address and the stored attributes.

After a miss, the requester obtains the translation elsewhere (a table walker, which is outside this block) and installs it through the fill port. The maintenance port removes stale slots in one of four ways: all slots, every slot of one identifier, the slot holding one address under the running identifier, or the slot holding one address under an identifier carried in the operand. An address-based removal also catches 2 MB and 1 GB slots whose range covers the given address.

Top module: `tlb_asid_cache`

## Requirements
- R1: After reset every slot is empty. `rsp_valid` and `rsp_hit` are low, and every lookup misses until a fill installs a slot.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `lk_valid` high. `rsp_hit` is never high without `rsp_valid`. On a miss, `rsp_pa` and `rsp_attr` are zero.
- R3: A lookup hits only on a valid slot whose stored identifier equals `lk_asid`. The same address under another identifier misses.
- R4: Size codes are 0 = 4 KB, 1 = 2 MB and 2 = 1 GB; code 3 behaves as 4 KB. The match ignores the address bits below the slot's page size (12, 21 or 30 bits). Fill address and fill physical address bits below the size are discarded. `rsp_pa` is the stored physical base above the size boundary joined with the lookup address bits below it.
- R5: A hit returns the attribute byte given at fill time.
- R6: A fill whose size-masked address, size and identifier equal those of a valid slot overwrites that slot. Otherwise the fill takes the lowest-numbered empty slot. If every slot is full, the fill replaces the slot at a round-robin pointer. The pointer starts at 0 after reset and moves up by one, wrapping, on each such replacement only.
- R7: Maintenance code 0 (`mnt_op`) empties every slot whatever its identifier or address.
- R8: Code 1 empties every slot whose identifier equals operand bits 63:48 and leaves all other identifiers intact.
- R9: Code 2 empties the slots of identifier `mnt_cur_asid` whose page contains the address in operand bits VA_W-1:12. The operand identifier field is ignored, and 2 MB and 1 GB slots are included.
- R10: Code 3 does the same as code 2, but with the identifier taken from operand bits 63:48 instead of `mnt_cur_asid`.
- R11: When maintenance and a lookup arrive in the same cycle, the lookup sees the slots already invalidated. A fill in the same cycle as maintenance is discarded.
- R12: A lookup in the same cycle as a fill sees the slots before the fill. A lookup in the next cycle sees the new slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Identifier of the running address space |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_attr | output | ATTR_W | Stored attribute byte |
| fill_valid | input | 1 | Install a translation |
| fill_va | input | VA_W | Virtual address of the new slot |
| fill_asid | input | ASID_W | Owner identifier of the new slot |
| fill_size | input | 2 | Page size code |
| fill_pa | input | PA_W | Physical address of the page |
| fill_attr | input | ATTR_W | Attribute byte |
| mnt_valid | input | 1 | Maintenance request |
| mnt_op | input | 2 | Maintenance kind (0 all, 1 identifier, 2 address, 3 address and identifier) |
| mnt_operand | input | 64 | Identifier in bits 63:48, page address in bits VA_W-1:12 |
| mnt_cur_asid | input | ASID_W | Running identifier used by code 2 |

## Verification
A corrupted slot (wrong identifier, wrong size mask or wrong base) shows at the ports one cycle after the next lookup of an address it covers. It appears as a wrong hit or miss flag, or as a physical address whose bits above the page boundary are wrong. A maintenance mask that is wrong shows as a slot that survives or dies; the bench probes this with lookups on both sides of each invalidation. A replacement pointer that is wrong is only visible after the cache fills up, so the bench fills every slot and reads back which translation was lost.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int PAGE_SHIFT = 12;

   localparam logic [1:0] SZ_4K = 2'd0;
   localparam logic [1:0] SZ_2M = 2'd1;
   localparam logic [1:0] SZ_1G = 2'd2;

   localparam logic [1:0] OP_ALL     = 2'd0;
   localparam logic [1:0] OP_ASID    = 2'd1;
   localparam logic [1:0] OP_VA      = 2'd2;
   localparam logic [1:0] OP_VA_ASID = 2'd3;

   // Number of page-number bits dropped above the 4 KB boundary.
   function automatic int unsigned vpn_drop(input logic [1:0] sz);
      case (sz)
         SZ_2M:   return 9;
         SZ_1G:   return 18;
         default: return 0;
      endcase
   endfunction

   function automatic int unsigned off_bits(input logic [1:0] sz);
      return PAGE_SHIFT + vpn_drop(sz);
   endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
   import tlb_pkg::*;
#(
   parameter int N      = 16,
   parameter int VPN_W  = 36,
   parameter int PPN_W  = 36,
   parameter int ASID_W = 16,
   parameter int ATTR_W = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              kill_en,
   input  logic              kill_all,
   input  logic              kill_va,
   input  logic [ASID_W-1:0] kill_asid,
   input  logic [VPN_W-1:0]  kill_vpn,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [1:0]        wr_size,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [ATTR_W-1:0] wr_attr,
   output logic [N-1:0]      valid_vec,
   output logic [N-1:0]      dup_vec,
   output logic              hit,
   output logic [PPN_W-1:0]  hit_ppn,
   output logic [1:0]        hit_size,
   output logic [ATTR_W-1:0] hit_attr
);
   function automatic logic [VPN_W-1:0] vmask(input logic [1:0] sz);
      return {VPN_W{1'b1}} << vpn_drop(sz);
   endfunction

   function automatic logic [PPN_W-1:0] pmask(input logic [1:0] sz);
      return {PPN_W{1'b1}} << vpn_drop(sz);
   endfunction

   logic [VPN_W-1:0]  vpn_q  [N];
   logic [PPN_W-1:0]  ppn_q  [N];
   logic [ASID_W-1:0] asid_q [N];
   logic [1:0]        size_q [N];
   logic [ATTR_W-1:0] attr_q [N];
   logic [N-1:0]      v_q;
   logic [N-1:0]      kill_vec;
   logic [N-1:0]      lk_vec;

   logic [VPN_W-1:0] wr_vpn_m;
   logic [PPN_W-1:0] wr_ppn_m;
   assign wr_vpn_m  = wr_vpn & vmask(wr_size);
   assign wr_ppn_m  = wr_ppn & pmask(wr_size);
   assign valid_vec = v_q;

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic asid_lk, asid_kill, va_lk, va_kill;
      assign asid_lk   = (asid_q[i] == lk_asid);
      assign asid_kill = (asid_q[i] == kill_asid);
      assign va_lk     = ((lk_vpn & vmask(size_q[i])) == vpn_q[i]);
      assign va_kill   = ((kill_vpn & vmask(size_q[i])) == vpn_q[i]);

      assign kill_vec[i] = kill_en & v_q[i] &
                           (kill_all | (asid_kill & (~kill_va | va_kill)));
      // invalidate wins over a lookup in the same cycle
      assign lk_vec[i]   = v_q[i] & asid_lk & va_lk & ~kill_vec[i];
      assign dup_vec[i]  = v_q[i] & (asid_q[i] == wr_asid) &
                           (size_q[i] == wr_size) & (vpn_q[i] == wr_vpn_m);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q[i]    <= 1'b0;
            vpn_q[i]  <= '0;
            ppn_q[i]  <= '0;
            asid_q[i] <= '0;
            size_q[i] <= SZ_4K;
            attr_q[i] <= '0;
         end else if (kill_vec[i]) begin
            v_q[i] <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            v_q[i]    <= 1'b1;
            vpn_q[i]  <= wr_vpn_m;
            ppn_q[i]  <= wr_ppn_m;
            asid_q[i] <= wr_asid;
            size_q[i] <= wr_size;
            attr_q[i] <= wr_attr;
         end
      end
   end

   // lowest-numbered match wins if overlapping sizes ever coincide
   always_comb begin
      hit      = 1'b0;
      hit_ppn  = '0;
      hit_size = SZ_4K;
      hit_attr = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (lk_vec[i]) begin
            hit      = 1'b1;
            hit_ppn  = ppn_q[i];
            hit_size = size_q[i];
            hit_attr = attr_q[i];
         end
      end
   end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
   parameter int N      = 16,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_go,
   input  logic [N-1:0]     valid_vec,
   input  logic [N-1:0]     dup_vec,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] rr_q;
   logic             evict;

   always_comb begin
      idx = rr_q;
      if (|dup_vec) begin
         for (int i = N - 1; i >= 0; i--)
            if (dup_vec[i]) idx = IDX_W'(i);
      end else if (!(&valid_vec)) begin
         for (int i = N - 1; i >= 0; i--)
            if (!valid_vec[i]) idx = IDX_W'(i);
      end
   end

   assign evict = fill_go & (&valid_vec) & ~(|dup_vec);

   always_ff @(posedge clk) begin
      if (!rst_n)
         rr_q <= '0;
      else if (evict)
         rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
   end
endmodule

// File: rtl/tlb_resp_stage.sv
module tlb_resp_stage
   import tlb_pkg::*;
#(
   parameter int PA_W   = 48,
   parameter int PPN_W  = 36,
   parameter int ATTR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              hit,
   input  logic [PPN_W-1:0]  hit_ppn,
   input  logic [1:0]        hit_size,
   input  logic [ATTR_W-1:0] hit_attr,
   input  logic [29:0]       va_low,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [ATTR_W-1:0] rsp_attr
);
   logic [PA_W-1:0] base, off_m, va_off, pa_d;

   assign base   = {hit_ppn, {PAGE_SHIFT{1'b0}}};
   assign off_m  = ~({PA_W{1'b1}} << off_bits(hit_size));
   assign va_off = PA_W'(va_low);
   assign pa_d   = (base & ~off_m) | (va_off & off_m);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_pa    <= '0;
         rsp_attr  <= '0;
      end else begin
         rsp_valid <= req;
         rsp_hit   <= req & hit;
         rsp_pa    <= (req & hit) ? pa_d : '0;
         rsp_attr  <= (req & hit) ? hit_attr : '0;
      end
   end
endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VA_W    = 48,
   parameter int PA_W    = 48,
   parameter int ASID_W  = 16,
   parameter int ATTR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [ATTR_W-1:0] rsp_attr,
   input  logic              fill_valid,
   input  logic [VA_W-1:0]   fill_va,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [1:0]        fill_size,
   input  logic [PA_W-1:0]   fill_pa,
   input  logic [ATTR_W-1:0] fill_attr,
   input  logic              mnt_valid,
   input  logic [1:0]        mnt_op,
   input  logic [63:0]       mnt_operand,
   input  logic [ASID_W-1:0] mnt_cur_asid
);
   localparam int VPN_W = VA_W - PAGE_SHIFT;
   localparam int PPN_W = PA_W - PAGE_SHIFT;
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int OPND_ASID_LSB = 48;

   if (ENTRIES < 8 || ENTRIES > 64) begin : g_bad_entries
      $error("ENTRIES must lie in 8..64");
   end
   if (VA_W < 31 || VA_W > OPND_ASID_LSB) begin : g_bad_va
      $error("VA_W must lie in 31..48");
   end
   if (PA_W < 31) begin : g_bad_pa
      $error("PA_W must be at least 31");
   end
   if (ASID_W < 1 || ASID_W > 16) begin : g_bad_asid
      $error("ASID_W must lie in 1..16");
   end

   logic              kill_all, kill_va, wr_en;
   logic [ASID_W-1:0] kill_asid;
   logic [VPN_W-1:0]  kill_vpn;
   logic [ENTRIES-1:0] valid_vec, dup_vec;
   logic [IDX_W-1:0]  wr_idx;
   logic              hit;
   logic [PPN_W-1:0]  hit_ppn;
   logic [1:0]        hit_size;
   logic [ATTR_W-1:0] hit_attr;
   logic              low_bits_unused;

   assign low_bits_unused = ^{mnt_operand[PAGE_SHIFT-1:0],
                              fill_va[PAGE_SHIFT-1:0], fill_pa[PAGE_SHIFT-1:0]};

   assign kill_all  = (mnt_op == OP_ALL);
   assign kill_va   = (mnt_op == OP_VA) || (mnt_op == OP_VA_ASID);
   assign kill_asid = (mnt_op == OP_VA) ? mnt_cur_asid
                                        : mnt_operand[OPND_ASID_LSB +: ASID_W];
   assign kill_vpn  = mnt_operand[VA_W-1:PAGE_SHIFT];
   assign wr_en     = fill_valid & ~mnt_valid;

   tlb_entry_array #(
      .N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
      .ASID_W(ASID_W), .ATTR_W(ATTR_W)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (lk_va[VA_W-1:PAGE_SHIFT]),
      .lk_asid   (lk_asid),
      .kill_en   (mnt_valid),
      .kill_all  (kill_all),
      .kill_va   (kill_va),
      .kill_asid (kill_asid),
      .kill_vpn  (kill_vpn),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_vpn    (fill_va[VA_W-1:PAGE_SHIFT]),
      .wr_size   (fill_size),
      .wr_asid   (fill_asid),
      .wr_ppn    (fill_pa[PA_W-1:PAGE_SHIFT]),
      .wr_attr   (fill_attr),
      .valid_vec (valid_vec),
      .dup_vec   (dup_vec),
      .hit       (hit),
      .hit_ppn   (hit_ppn),
      .hit_size  (hit_size),
      .hit_attr  (hit_attr)
   );

   tlb_victim_sel #(.N(ENTRIES)) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_go   (wr_en),
      .valid_vec (valid_vec),
      .dup_vec   (dup_vec),
      .idx       (wr_idx)
   );

   tlb_resp_stage #(.PA_W(PA_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (lk_valid),
      .hit       (hit),
      .hit_ppn   (hit_ppn),
      .hit_size  (hit_size),
      .hit_attr  (hit_attr),
      .va_low    (lk_va[29:0]),
      .rsp_valid (rsp_valid),
      .rsp_hit   (rsp_hit),
      .rsp_pa    (rsp_pa),
      .rsp_attr  (rsp_attr)
   );
endmodule

// File: rtl/tlb_asid_cache_chk.sv
module tlb_asid_cache_chk #(
   parameter int PA_W   = 48,
   parameter int ATTR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [11:0]       lk_va_low,
   input logic              mnt_valid,
   input logic [1:0]        mnt_op,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [PA_W-1:0]   rsp_pa,
   input logic [ATTR_W-1:0] rsp_attr
);
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);                                            // R2
   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);                                          // R2
   AST_HIT_HAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);                                             // R2
   AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && rsp_attr == '0));     // R2
   AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!rsp_hit || rsp_pa[11:0] == $past(lk_va_low)));       // R4
   AST_FLUSH_BEATS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      (mnt_valid && mnt_op == 2'd0) |=> !rsp_hit);                        // R11
endmodule

bind tlb_asid_cache tlb_asid_cache_chk #(.PA_W(PA_W), .ATTR_W(ATTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_valid  (lk_valid),
   .lk_va_low (lk_va[11:0]),
   .mnt_valid (mnt_valid),
   .mnt_op    (mnt_op),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_pa    (rsp_pa),
   .rsp_attr  (rsp_attr)
);

// File: tb/tlb_asid_cache_tb.sv
module tlb_asid_cache_tb;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [47:0] lk_va = '0;
   logic [15:0] lk_asid = '0;
   logic        rsp_valid, rsp_hit;
   logic [47:0] rsp_pa;
   logic [7:0]  rsp_attr;
   logic        fill_valid = 1'b0;
   logic [47:0] fill_va = '0;
   logic [15:0] fill_asid = '0;
   logic [1:0]  fill_size = '0;
   logic [47:0] fill_pa = '0;
   logic [7:0]  fill_attr = '0;
   logic        mnt_valid = 1'b0;
   logic [1:0]  mnt_op = '0;
   logic [63:0] mnt_operand = '0;
   logic [15:0] mnt_cur_asid = '0;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   tlb_asid_cache #(.ENTRIES(N)) u_dut (.*);

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic logic [47:0] exp_pa(input logic [47:0] pa, input logic [47:0] va,
                                          input logic [1:0] sz);
      logic [47:0] m;
      m = (sz == 2'd1) ? 48'h1F_FFFF : (sz == 2'd2) ? 48'h3FFF_FFFF : 48'hFFF;
      return (pa & ~m) | (va & m);
   endfunction

   task automatic fill(input logic [47:0] va, input logic [15:0] asid, input logic [1:0] sz,
                       input logic [47:0] pa, input logic [7:0] attr);
      @(negedge clk);
      fill_valid = 1'b1; fill_va = va; fill_asid = asid;
      fill_size = sz; fill_pa = pa; fill_attr = attr;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic mnt(input logic [1:0] op, input logic [63:0] opnd, input logic [15:0] cur);
      @(negedge clk);
      mnt_valid = 1'b1; mnt_op = op; mnt_operand = opnd; mnt_cur_asid = cur;
      @(negedge clk);
      mnt_valid = 1'b0;
   endtask

   // response sampled on the negedge after the capturing posedge
   task automatic look(input string req, input logic [47:0] va, input logic [15:0] asid,
                       input logic ehit, input logic [47:0] epa, input logic [7:0] eattr);
      @(negedge clk);
      lk_valid = 1'b1; lk_va = va; lk_asid = asid;
      @(negedge clk);
      lk_valid = 1'b0;
      check({req, " valid"}, 64'(rsp_valid), 64'd1);
      check({req, " hit"}, 64'(rsp_hit), 64'(ehit));
      check({req, " pa"}, 64'(rsp_pa), ehit ? 64'(epa) : 64'd0);
      check({req, " attr"}, 64'(rsp_attr), ehit ? 64'(eattr) : 64'd0);
   endtask

   localparam logic [47:0] VA_A = 48'h0000_1234_5000, PA_A = 48'h0000_8888_9000;
   localparam logic [47:0] VA_B = 48'h0000_4020_0000, PA_B = 48'h0001_0060_0000;
   localparam logic [47:0] VA_C = 48'h0080_4000_0000, PA_C = 48'h0000_C000_0000;

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
      check("R1 reset rsp_hit", 64'(rsp_hit), 64'd0);
      rst_n = 1'b1;
      look("R1 empty after reset", 48'h1000, 16'd1, 1'b0, '0, '0);
      @(negedge clk);
      check("R2 idle after response", 64'(rsp_valid), 64'd0);

      // R4 R5: three sizes, fill addresses carry junk below the boundary
      fill(VA_A, 16'd5, 2'd0, PA_A, 8'h3C);
      fill(VA_B | 48'h1_2345, 16'd5, 2'd1, PA_B | 48'h7_7000, 8'h51);
      fill(VA_C | 48'h123_4000, 16'd5, 2'd2, PA_C | 48'h55_5000, 8'h7E);
      for (int k = 0; k < 16; k++) begin
         logic [47:0] o4, o2, o1;
         o4 = 48'(k * 273); o2 = 48'(k * 131071); o1 = 48'(k * 67108863);
         look("R4 4K sweep", VA_A + o4, 16'd5, 1'b1, exp_pa(PA_A, VA_A + o4, 2'd0), 8'h3C);
         look("R4 2M sweep", VA_B + o2, 16'd5, 1'b1, exp_pa(PA_B, VA_B + o2, 2'd1), 8'h51);
         look("R5 1G sweep", VA_C + o1, 16'd5, 1'b1, exp_pa(PA_C, VA_C + o1, 2'd2), 8'h7E);
      end
      look("R4 4K next page", VA_A + 48'h1000, 16'd5, 1'b0, '0, '0);
      look("R4 2M next page", VA_B + 48'h20_0000, 16'd5, 1'b0, '0, '0);
      look("R4 1G next page", VA_C + 48'h4000_0000, 16'd5, 1'b0, '0, '0);
      look("R3 other asid", VA_A, 16'd6, 1'b0, '0, '0);
      look("R3 other asid 1G", VA_C, 16'd4, 1'b0, '0, '0);

      // R12: lookup with fill in the same cycle sees old state
      @(negedge clk);
      fill_valid = 1'b1; fill_va = 48'h2000; fill_asid = 16'd5; fill_size = 2'd0;
      fill_pa = 48'hABC000; fill_attr = 8'h11;
      lk_valid = 1'b1; lk_va = 48'h2004; lk_asid = 16'd5;
      @(negedge clk);
      fill_valid = 1'b0; lk_valid = 1'b0;
      check("R12 same-cycle fill miss", 64'(rsp_hit), 64'd0);
      look("R12 next-cycle hit", 48'h2004, 16'd5, 1'b1, 48'hABC004, 8'h11);

      // R8: by identifier
      fill(VA_A, 16'd6, 2'd0, 48'h7777_7000, 8'h22);
      mnt(2'd1, {16'd5, 48'h0}, 16'd6);
      look("R8 asid5 4K gone", VA_A, 16'd5, 1'b0, '0, '0);
      look("R8 asid5 2M gone", VA_B, 16'd5, 1'b0, '0, '0);
      look("R8 asid5 1G gone", VA_C, 16'd5, 1'b0, '0, '0);
      look("R8 asid6 kept", VA_A + 48'h10, 16'd6, 1'b1, 48'h7777_7010, 8'h22);

      // R7: everything
      mnt(2'd0, 64'hFFFF_0000_0000_0000, 16'd0);
      look("R7 flush all", VA_A, 16'd6, 1'b0, '0, '0);

      // R9: address under running identifier
      fill(VA_A, 16'd5, 2'd0, PA_A, 8'h3C);
      fill(VA_A, 16'd6, 2'd0, 48'h7777_7000, 8'h22);
      fill(VA_B, 16'd5, 2'd1, PA_B, 8'h51);
      mnt(2'd2, {16'd6, VA_A}, 16'd5);
      look("R9 cur asid removed", VA_A, 16'd5, 1'b0, '0, '0);
      look("R9 operand asid ignored", VA_A, 16'd6, 1'b1, 48'h7777_7000, 8'h22);
      mnt(2'd2, {16'd0, VA_B + 48'h3_4000}, 16'd5);
      look("R9 2M covered removed", VA_B, 16'd5, 1'b0, '0, '0);

      // R10: address with operand identifier
      fill(VA_C, 16'd6, 2'd2, PA_C, 8'h7E);
      mnt(2'd3, {16'd6, VA_A}, 16'd5);
      look("R10 operand asid removed", VA_A, 16'd6, 1'b0, '0, '0);
      look("R10 1G untouched", VA_C, 16'd6, 1'b1, PA_C, 8'h7E);
      mnt(2'd3, {16'd6, VA_C + 48'h2345_6000}, 16'd5);
      look("R10 1G covered removed", VA_C, 16'd6, 1'b0, '0, '0);

      // R11: priority against lookup and fill
      fill(VA_A, 16'd9, 2'd0, PA_A, 8'h3C);
      @(negedge clk);
      mnt_valid = 1'b1; mnt_op = 2'd0; mnt_operand = '0;
      lk_valid = 1'b1; lk_va = VA_A; lk_asid = 16'd9;
      @(negedge clk);
      mnt_valid = 1'b0; lk_valid = 1'b0;
      check("R11 flush beats lookup", 64'(rsp_hit), 64'd0);
      @(negedge clk);
      mnt_valid = 1'b1; mnt_op = 2'd1; mnt_operand = {16'd99, 48'h0};
      fill_valid = 1'b1; fill_va = VA_A; fill_asid = 16'd9; fill_size = 2'd0;
      fill_pa = PA_A; fill_attr = 8'h3C;
      @(negedge clk);
      mnt_valid = 1'b0; fill_valid = 1'b0;
      look("R11 fill dropped", VA_A, 16'd9, 1'b0, '0, '0);

      // R6: fill all slots, overwrite one, then evict in pointer order
      mnt(2'd0, '0, '0);
      for (int i = 0; i < N; i++)
         fill(48'h10_0000 + 48'(i) * 48'h1_0000, 16'd7, 2'd0, 48'h50_0000 + 48'(i) * 48'h1000, 8'(i));
      fill(48'h13_0000, 16'd7, 2'd0, 48'h99_9000, 8'hEE);
      for (int i = 0; i < N; i++) begin
         logic [47:0] va;
         va = 48'h10_0000 + 48'(i) * 48'h1_0000;
         if (i == 3) look("R6 overwrite in place", va, 16'd7, 1'b1, 48'h99_9000, 8'hEE);
         else look("R6 all slots held", va, 16'd7, 1'b1, 48'h50_0000 + 48'(i) * 48'h1000, 8'(i));
      end
      fill(48'h90_0000, 16'd7, 2'd0, 48'hA0_0000, 8'hA0);
      look("R6 slot0 evicted", 48'h10_0000, 16'd7, 1'b0, '0, '0);
      look("R6 slot1 kept", 48'h11_0000, 16'd7, 1'b1, 48'h50_1000, 8'h01);
      look("R6 new entry", 48'h90_0000, 16'd7, 1'b1, 48'hA0_0000, 8'hA0);
      fill(48'h91_0000, 16'd7, 2'd0, 48'hA1_0000, 8'hA1);
      look("R6 slot1 evicted next", 48'h11_0000, 16'd7, 1'b0, '0, '0);
      look("R6 slot2 kept", 48'h12_0000, 16'd7, 1'b1, 48'h50_2000, 8'h02);
      look("R6 second new entry", 48'h91_0000, 16'd7, 1'b1, 48'hA1_0000, 8'hA1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule